// File: doc/BRIEF.md
# Flash Page Operation Sequencer

This block is the self-timed engine inside a model of a page-organized serial flash. It owns a main array of pages and a single page-sized buffer. A front end, which is not part of this block, shifts in the command. It then hands over a decoded opcode and a page number, and it pulses `start` at the moment chip select returns high. The engine then runs one of seven operations on its own. These are: copy a page into the buffer, compare a page against the buffer, erase then program a page from the buffer, program a page without erasing it, erase one page, erase an aligned block of pages, and rewrite a page through the buffer.

Each operation is a sequence of phases, and every phase lasts a fixed number of clock cycles set by a parameter. The phase states are `ST_XFER` (page to buffer), `ST_CMP` (page against buffer), `ST_ERASE` (page to all ones), `ST_PROG` (buffer ANDed into page) and `ST_BERASE` (block to all ones). The idle state is `ST_IDLE`. The transitions are:
- `ST_IDLE` goes to the first phase of an accepted command.
- `ST_XFER` goes to `ST_ERASE` for the rewrite opcode, and to `ST_IDLE` otherwise.
- `ST_ERASE` goes to `ST_PROG` for the two erase-and-program opcodes, and to `ST_IDLE` for page erase.
- `ST_CMP`, `ST_PROG` and `ST_BERASE` go to `ST_IDLE`.

A phase changes the array, the buffer or the compare flag only on its last cycle. While any phase runs, `busy` and `rdy_pull_low` are high. A write-protect input sampled at start shields the low page range from erase and program.

Top module: `flash_page_seq`

## Requirements
- R1: While idle, `buf_we` writes `buf_wdata` into buffer byte `buf_addr`. `buf_rdata` always shows buffer byte `buf_addr`, with no clock delay.
- R2: A `start` pulse in idle is accepted only when `opcode` is 8'h53, 8'h60, 8'h83, 8'h88, 8'h81, 8'h50 or 8'h58. Any other opcode leaves the engine idle. `busy` rises in the cycle after an accepted start, and `rdy_pull_low` always equals `busy`.
- R3: Opcode 8'h53 holds `busy` for T_XFER cycles. At the end, the buffer equals the addressed page.
- R4: Opcode 8'h60 holds `busy` for T_CMP cycles. At the end, `cmp_diff` becomes 0 if every byte of the page equals the buffer, and 1 otherwise. `cmp_diff` changes at no other time.
- R5: Opcode 8'h83 holds `busy` for T_ERASE+T_PROG cycles. At the end, the page equals the buffer.
- R6: Opcode 8'h88 holds `busy` for T_PROG cycles. It replaces each page byte with (page AND buffer).
- R7: Opcode 8'h81 holds `busy` for T_ERASE cycles. It sets every byte of the page to 8'hFF.
- R8: Opcode 8'h50 holds `busy` for T_BERASE cycles. It sets to 8'hFF all BLOCK_PAGES pages whose upper page bits match the page address. The low log2(BLOCK_PAGES) bits of the page address are ignored.
- R9: Opcode 8'h58 holds `busy` for T_XFER+T_ERASE+T_PROG cycles. It copies the page into the buffer and then writes it back to the same page. Both the page and the buffer end up equal to the old page.
- R10: If `wp_n` is 0 when a command is accepted, erase and program leave every page below PROT_PAGES unchanged. The busy time stays the same. Pages at or above PROT_PAGES are still changed.
- R11: `start` and `buf_we` are ignored while `busy` is high.
- R12: While `rst_n` is low, the engine is held in idle and `cmp_diff` is held at 0. An operation cut short by reset leaves its page unchanged if its last phase cycle was not reached. `busy` is low in the cycle after `rst_n` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, aborts and holds idle |
| start | input | 1 | One-cycle pulse marking the chip-select rising edge |
| opcode | input | 8 | Decoded command code |
| page | input | PAGE_W | Page address of the command |
| wp_n | input | 1 | Write protect, low shields pages below PROT_PAGES |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_addr | input | BYTE_W | Buffer byte address |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer byte at buf_addr |
| busy | output | 1 | High while an operation runs |
| rdy_pull_low | output | 1 | Enable of the open-drain ready/busy pull-down |
| cmp_diff | output | 1 | Result of the most recent compare, 1 on mismatch |

## Verification
On every cycle the assertions check four things:
- `rdy_pull_low` tracks `busy`.
- An accepted command raises `busy` one cycle later, while a bad opcode leaves it low.
- `busy` only rises after a start pulse, and `cmp_diff` holds steady whenever the engine is idle.
- Reset forces idle.

The exact length of each compound sequence cannot be shown by these properties. Neither can the byte-level effects: AND-programming, block alignment, the protected range, rewrite through the buffer, and an aborted erase leaving data intact. The bench shows these by running scenarios against its reference model, and by reading pages back through the buffer after a transfer.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam logic [7:0] OP_XFER    = 8'h53;
    localparam logic [7:0] OP_CMP     = 8'h60;
    localparam logic [7:0] OP_ERPROG  = 8'h83;
    localparam logic [7:0] OP_PROG    = 8'h88;
    localparam logic [7:0] OP_PERASE  = 8'h81;
    localparam logic [7:0] OP_BERASE  = 8'h50;
    localparam logic [7:0] OP_REWRITE = 8'h58;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_CMP,
        ST_ERASE,
        ST_PROG,
        ST_BERASE
    } fps_state_e;

    function automatic logic op_valid(input logic [7:0] op);
        return (op == OP_XFER) || (op == OP_CMP) || (op == OP_ERPROG) ||
               (op == OP_PROG) || (op == OP_PERASE) || (op == OP_BERASE) ||
               (op == OP_REWRITE);
    endfunction

endpackage

// File: rtl/fps_timer.sv
module fps_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fps_store.sv
module fps_store #(
    parameter int PAGE_BYTES  = 8,
    parameter int NUM_PAGES   = 32,
    parameter int BLOCK_PAGES = 8,
    parameter int PROT_PAGES  = 16,
    localparam int PAGE_W = $clog2(NUM_PAGES),
    localparam int BYTE_W = $clog2(PAGE_BYTES),
    localparam int BLK_W  = $clog2(BLOCK_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_xfer,
    input  logic              act_cmp,
    input  logic              act_erase,
    input  logic              act_prog,
    input  logic              act_berase,
    input  logic [PAGE_W-1:0] pg,
    input  logic              wp_n_q,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              cmp_diff
);
    logic [7:0]        mem_q [NUM_PAGES][PAGE_BYTES];
    logic [7:0]        buf_q [PAGE_BYTES];
    logic              diff;
    logic [PAGE_W-1:0] blk_base;

    function automatic logic locked(input logic [PAGE_W-1:0] p, input logic wpn);
        return !wpn && (int'(p) < PROT_PAGES);
    endfunction

    assign blk_base   = (pg >> BLK_W) << BLK_W;
    assign host_rdata = buf_q[host_addr];

    always_comb begin
        diff = 1'b0;
        for (int b = 0; b < PAGE_BYTES; b++) begin
            diff = diff | (mem_q[pg][b] != buf_q[b]);
        end
    end

    always_ff @(posedge clk) begin
        if (act_erase && !locked(pg, wp_n_q)) begin
            for (int b = 0; b < PAGE_BYTES; b++) mem_q[pg][b] <= 8'hFF;
        end
        if (act_prog && !locked(pg, wp_n_q)) begin
            for (int b = 0; b < PAGE_BYTES; b++) mem_q[pg][b] <= mem_q[pg][b] & buf_q[b];
        end
        if (act_berase) begin
            for (int p = 0; p < BLOCK_PAGES; p++) begin
                if (!locked(blk_base + PAGE_W'(p), wp_n_q)) begin
                    for (int b = 0; b < PAGE_BYTES; b++) mem_q[blk_base + PAGE_W'(p)][b] <= 8'hFF;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (act_xfer) begin
            for (int b = 0; b < PAGE_BYTES; b++) buf_q[b] <= mem_q[pg][b];
        end else if (host_we) begin
            buf_q[host_addr] <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_diff <= 1'b0;
        end else if (act_cmp) begin
            cmp_diff <= diff;
        end
    end
endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
    import fps_pkg::*;
#(
    parameter int PAGE_BYTES  = 8,
    parameter int NUM_PAGES   = 32,
    parameter int BLOCK_PAGES = 8,
    parameter int PROT_PAGES  = 16,
    parameter int T_XFER      = 5,
    parameter int T_CMP       = 4,
    parameter int T_ERASE     = 7,
    parameter int T_PROG      = 9,
    parameter int T_BERASE    = 11,
    localparam int PAGE_W = $clog2(NUM_PAGES),
    localparam int BYTE_W = $clog2(PAGE_BYTES),
    localparam int MAX_A  = (T_XFER > T_CMP) ? T_XFER : T_CMP,
    localparam int MAX_B  = (T_ERASE > T_PROG) ? T_ERASE : T_PROG,
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
    localparam int MAX_T  = (MAX_C > T_BERASE) ? MAX_C : T_BERASE,
    localparam int CNT_W  = $clog2(MAX_T) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [PAGE_W-1:0] page,
    input  logic              wp_n,
    input  logic              buf_we,
    input  logic [BYTE_W-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata,
    output logic              busy,
    output logic              rdy_pull_low,
    output logic              cmp_diff
);
    fps_state_e        state_q, state_d;
    logic [7:0]        op_q;
    logic [PAGE_W-1:0] page_q;
    logic              wp_q;
    logic              accept, tmr_zero, tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              act_xfer, act_cmp, act_erase, act_prog, act_berase;

    assign accept = (state_q == ST_IDLE) && start && op_valid(opcode);

    // state register and command latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            page_q  <= '0;
            wp_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= opcode;
                page_q <= page;
                wp_q   <= wp_n;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (opcode)
                        OP_XFER, OP_REWRITE:   state_d = ST_XFER;
                        OP_CMP:                state_d = ST_CMP;
                        OP_ERPROG, OP_PERASE:  state_d = ST_ERASE;
                        OP_PROG:               state_d = ST_PROG;
                        default:               state_d = ST_BERASE;
                    endcase
                end
            end
            ST_XFER:   if (tmr_zero) state_d = (op_q == OP_REWRITE) ? ST_ERASE : ST_IDLE;
            ST_CMP:    if (tmr_zero) state_d = ST_IDLE;
            ST_ERASE:  if (tmr_zero) state_d = (op_q == OP_PERASE) ? ST_IDLE : ST_PROG;
            ST_PROG:   if (tmr_zero) state_d = ST_IDLE;
            ST_BERASE: if (tmr_zero) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs, phase actions and timer load
    always_comb begin
        busy       = (state_q != ST_IDLE);
        act_xfer   = tmr_zero && (state_q == ST_XFER);
        act_cmp    = tmr_zero && (state_q == ST_CMP);
        act_erase  = tmr_zero && (state_q == ST_ERASE);
        act_prog   = tmr_zero && (state_q == ST_PROG);
        act_berase = tmr_zero && (state_q == ST_BERASE);
        tmr_load   = (state_d != state_q) && (state_d != ST_IDLE);
        unique case (state_d)
            ST_XFER:   tmr_val = CNT_W'(T_XFER - 1);
            ST_CMP:    tmr_val = CNT_W'(T_CMP - 1);
            ST_ERASE:  tmr_val = CNT_W'(T_ERASE - 1);
            ST_PROG:   tmr_val = CNT_W'(T_PROG - 1);
            ST_BERASE: tmr_val = CNT_W'(T_BERASE - 1);
            default:   tmr_val = '0;
        endcase
    end

    assign rdy_pull_low = busy;

    fps_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    fps_store #(
        .PAGE_BYTES  (PAGE_BYTES),
        .NUM_PAGES   (NUM_PAGES),
        .BLOCK_PAGES (BLOCK_PAGES),
        .PROT_PAGES  (PROT_PAGES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_xfer   (act_xfer),
        .act_cmp    (act_cmp),
        .act_erase  (act_erase),
        .act_prog   (act_prog),
        .act_berase (act_berase),
        .pg         (page_q),
        .wp_n_q     (wp_q),
        .host_we    (buf_we && !busy),
        .host_addr  (buf_addr),
        .host_wdata (buf_wdata),
        .host_rdata (buf_rdata),
        .cmp_diff   (cmp_diff)
    );
endmodule

// File: rtl/fps_checker.sv
module fps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] opcode,
    input logic       busy,
    input logic       rdy_pull_low,
    input logic       cmp_diff
);
    assert_rdy_tracks_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_pull_low == busy);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && fps_pkg::op_valid(opcode)) |=> busy);

    assert_bad_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !fps_pkg::op_valid(opcode)) |=> !busy);

    assert_busy_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_cmp_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(cmp_diff));

    assert_reset_idle_R12: assert property (@(posedge clk)
        !rst_n |=> (!busy && !cmp_diff));
endmodule

bind flash_page_seq fps_checker u_fps_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .opcode       (opcode),
    .busy         (busy),
    .rdy_pull_low (rdy_pull_low),
    .cmp_diff     (cmp_diff)
);

// File: tb/flash_page_seq_tb_top.sv
module flash_page_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PB  = 8;
    localparam int NP  = 32;
    localparam int BP  = 8;
    localparam int PR  = 16;
    localparam int TX  = 5;
    localparam int TC  = 4;
    localparam int TE  = 7;
    localparam int TP  = 9;
    localparam int TB  = 11;
    localparam int PW  = $clog2(NP);
    localparam int BW  = $clog2(PB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    opcode = '0;
    logic [PW-1:0] page = '0;
    logic          wp_n = 1'b1;
    logic          buf_we = 1'b0;
    logic [BW-1:0] buf_addr = '0;
    logic [7:0]    buf_wdata = '0;
    logic [7:0]    buf_rdata;
    logic          busy, rdy_pull_low, cmp_diff;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R12";
    bit    buf_known = 0;

    flash_page_seq #(
        .PAGE_BYTES(PB), .NUM_PAGES(NP), .BLOCK_PAGES(BP), .PROT_PAGES(PR),
        .T_XFER(TX), .T_CMP(TC), .T_ERASE(TE), .T_PROG(TP), .T_BERASE(TB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .page(page),
        .wp_n(wp_n), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .busy(busy), .rdy_pull_low(rdy_pull_low),
        .cmp_diff(cmp_diff)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] mm [NP][PB];
    logic [7:0] bm [PB];
    bit         m_cmp = 0;
    int         phq[$];
    int         rem = 0;
    int         m_page = 0;
    bit         m_wp = 1;

    function automatic int dur(input int ph);
        case (ph)
            1: return TX;
            2: return TC;
            3: return TE;
            4: return TP;
            default: return TB;
        endcase
    endfunction

    function automatic bit prot(input int p);
        return !m_wp && (p < PR);
    endfunction

    task automatic apply(input int ph);
        bit d;
        case (ph)
            1: for (int b = 0; b < PB; b++) bm[b] = mm[m_page][b];
            2: begin
                d = 0;
                for (int b = 0; b < PB; b++) if (mm[m_page][b] != bm[b]) d = 1;
                m_cmp = d;
            end
            3: if (!prot(m_page)) for (int b = 0; b < PB; b++) mm[m_page][b] = 8'hFF;
            4: if (!prot(m_page)) for (int b = 0; b < PB; b++) mm[m_page][b] &= bm[b];
            default: begin
                for (int p = m_page - (m_page % BP); p < m_page - (m_page % BP) + BP; p++)
                    if (!prot(p)) for (int b = 0; b < PB; b++) mm[p][b] = 8'hFF;
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            phq.delete();
            rem = 0;
            m_cmp = 0;
        end else if (phq.size() != 0) begin
            rem--;
            if (rem == 0) begin
                apply(phq[0]);
                void'(phq.pop_front());
                if (phq.size() != 0) rem = dur(phq[0]);
            end
        end else begin
            if (buf_we) bm[buf_addr] = buf_wdata;
            if (start) begin
                m_page = int'(page);
                m_wp = wp_n;
                case (opcode)
                    8'h53: phq = '{1};
                    8'h60: phq = '{2};
                    8'h83: phq = '{3, 4};
                    8'h88: phq = '{4};
                    8'h81: phq = '{3};
                    8'h50: phq = '{5};
                    8'h58: phq = '{1, 3, 4};
                    default: phq.delete();
                endcase
                if (phq.size() != 0) rem = dur(phq[0]);
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        check(busy == (phq.size() != 0), cur_req, "busy", busy, phq.size() != 0);
        check(rdy_pull_low == busy, "R2", "rdy_pull_low", rdy_pull_low, busy);
        check(cmp_diff == m_cmp, cur_req, "cmp_diff", cmp_diff, m_cmp);
        if (buf_known)
            check(buf_rdata == bm[buf_addr], cur_req, "buf_rdata", buf_rdata, bm[buf_addr]);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] pat_a(input int b);
        return 8'(b * 37 + 5);
    endfunction

    function automatic logic [7:0] pat_b(input int b);
        return 8'(~(b * 11 + 64));
    endfunction

    task automatic wr_buf(input int a, input logic [7:0] d);
        buf_we = 1; buf_addr = BW'(a); buf_wdata = d;
        tick();
        buf_we = 0;
    endtask

    task automatic fill(input bit use_b);
        for (int b = 0; b < PB; b++) wr_buf(b, use_b ? pat_b(b) : pat_a(b));
        buf_known = 1;
    endtask

    task automatic run(input logic [7:0] op, input int pg, input int exp_len,
                       input string req);
        int len = 0;
        cur_req = req;
        start = 1; opcode = op; page = PW'(pg);
        tick();
        start = 0;
        while (busy) begin
            len++;
            tick();
        end
        check(len == exp_len, req, "busy length", len, exp_len);
    endtask

    task automatic peek(input int a, input logic [7:0] exp, input string req);
        buf_addr = BW'(a);
        #1;
        check(buf_rdata == exp, req, "buffer byte", buf_rdata, exp);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) tick();
        check(busy == 0 && cmp_diff == 0, "R12", "reset state", {busy, cmp_diff}, 0);
        rst_n = 1;
        tick();

        // R1 host buffer access
        cur_req = "R1";
        fill(0);
        peek(3, pat_a(3), "R1");

        // R5 erase+program page 20 with pattern A
        run(8'h83, 20, TE + TP, "R5");
        // R2 invalid opcode ignored
        run(8'h57, 20, 0, "R2");

        // R4 compare matching then mismatching
        run(8'h60, 20, TC, "R4");
        check(cmp_diff == 0, "R4", "match", cmp_diff, 0);
        wr_buf(2, 8'h00);
        run(8'h60, 20, TC, "R4");
        check(cmp_diff == 1, "R4", "mismatch", cmp_diff, 1);

        // R3 transfer restores the buffer
        run(8'h53, 20, TX, "R3");
        peek(2, pat_a(2), "R3");
        check(cmp_diff == 1, "R4", "sticky after transfer", cmp_diff, 1);

        // R6 program without erase ANDs
        fill(1);
        run(8'h88, 20, TP, "R6");
        run(8'h53, 20, TX, "R6");
        peek(5, pat_a(5) & pat_b(5), "R6");

        // R7 page erase
        run(8'h81, 20, TE, "R7");
        run(8'h53, 20, TX, "R7");
        peek(0, 8'hFF, "R7");

        // R8 block erase: program pages 17 and 24, erase block addressed by 21
        fill(0);
        run(8'h83, 17, TE + TP, "R8");
        run(8'h83, 24, TE + TP, "R8");
        run(8'h50, 21, TB, "R8");
        run(8'h53, 17, TX, "R8");
        peek(1, 8'hFF, "R8");
        run(8'h53, 24, TX, "R8");
        peek(1, pat_a(1), "R8");

        // R10 write protect on page 3, unprotected page 20 still erased
        fill(1);
        run(8'h83, 3, TE + TP, "R10");
        wp_n = 0;
        run(8'h81, 3, TE, "R10");
        run(8'h50, 2, TB, "R10");
        run(8'h53, 3, TX, "R10");
        peek(4, pat_b(4), "R10");
        fill(0);
        run(8'h83, 20, TE + TP, "R10");
        run(8'h53, 20, TX, "R10");
        peek(4, pat_a(4), "R10");
        wp_n = 1;

        // R9 rewrite: buffer scrambled, page 20 keeps pattern A
        fill(1);
        run(8'h58, 20, TX + TE + TP, "R9");
        peek(6, pat_a(6), "R9");
        run(8'h60, 20, TC, "R9");
        check(cmp_diff == 0, "R9", "page equals buffer", cmp_diff, 0);

        // R11 start and buffer writes during busy are ignored
        cur_req = "R11";
        start = 1; opcode = 8'h81; page = PW'(20);
        tick();
        opcode = 8'h53; page = PW'(24);
        buf_we = 1; buf_addr = BW'(6); buf_wdata = 8'h11;
        tick();
        start = 0; buf_we = 0;
        repeat (TE) tick();
        check(busy == 0, "R11", "second start ignored", busy, 0);
        peek(6, pat_a(6), "R11");

        // R12 reset aborts erase of page 24 before it completes
        cur_req = "R12";
        start = 1; opcode = 8'h81; page = PW'(24);
        tick();
        start = 0;
        repeat (3) tick();
        rst_n = 0;
        tick();
        check(busy == 0, "R12", "abort", busy, 0);
        tick();
        rst_n = 1;
        tick();
        run(8'h53, 24, TX, "R12");
        peek(7, pat_a(7), "R12");

        repeat (2) tick();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule